// File: doc/BRIEF.md
# Serial Bit-Stream Input Receiver

This receiver takes audio data from a three-wire serial link made of a bit clock, a word strobe and a data line. It writes what it receives into an internal FIFO. Each FIFO entry holds one byte and a channel tag. The bit clock is asynchronous to the system clock. All three wires pass through a two-flop synchroniser, and each bit is taken on a detected rising edge of the synchronised bit clock.

A mode input selects one of two framings:

- **Continuous bit-stream mode.** The receiver ignores the word strobe, which the source holds low. It packs the compressed stream into bytes in the order it arrives, MSB first.
- **Word-oriented mode.** The strobe frames I2S-style left and right PCM samples. Each 16-bit sample is stored as two tagged bytes.

An end-of-data output with hysteresis tells the upstream source to pause while the FIFO is nearly full. This serves demand-driven delivery, where the bit clock runs faster than the stream rate and only this flag regulates flow.

Top module: `serial_stream_rx`

## Requirements
- R1: The bit clock, strobe and data inputs each pass through two synchronising flops. A data bit and its strobe level are taken once per rising bit-clock edge.
- R2: With `mode_pcm`=0, every 8 received bits form one FIFO entry. The first received bit lands in bit 7, and the channel tag is 0.
- R3: With `mode_pcm`=0, the strobe level and its changes have no effect on the stored bytes.
- R4: With `mode_pcm`=1, a word begins at the bit edge where the sampled strobe differs from the level sampled at the previous edge. The bit taken at that edge is discarded. The next 16 bits form one sample, MSB first.
- R5: Each PCM sample is written as two entries, high byte first. Both entries carry a tag equal to the strobe level of that phase (0 = left, 1 = right).
- R6: In PCM mode, bits after the 16th within one strobe phase are discarded. Bits that arrive before the first strobe change after reset or after a mode change are also discarded.
- R7: `eod` is 1 in the cycle after the FIFO fill level reaches DEPTH-4 or more.
- R8: `eod` returns to 0 in the cycle after the fill level is DEPTH/2 or less. Between the two levels, `eod` keeps its value.
- R9: A byte that arrives while the FIFO holds DEPTH entries is dropped. The stored entries stay unchanged.
- R10: After reset, `data_avail`, `eod` and `rd_valid` are 0. When `rd_en` is high while `data_avail` is 1, the oldest entry appears on `rd_data`/`rd_chan` with `rd_valid`=1 in the next cycle.
- R11: A change of `mode_pcm` discards any partly assembled byte or sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pcm | input | 1 | 0: bit-stream mode, 1: PCM word mode |
| sck | input | 1 | Serial bit clock (asynchronous) |
| sws | input | 1 | Word strobe / channel select |
| sdat | input | 1 | Serial data |
| rd_en | input | 1 | Pop one FIFO entry |
| rd_data | output | 8 | Popped byte |
| rd_chan | output | 1 | Channel tag of popped byte |
| rd_valid | output | 1 | rd_data/rd_chan valid this cycle |
| data_avail | output | 1 | FIFO not empty |
| eod | output | 1 | End-of-data: source must pause |

## Verification
A rising bit-clock edge becomes visible to the assembler two system cycles after it appears. The byte it completes is written one cycle later, and the fill level moves one cycle after that. A PCM low byte follows its high byte by one further cycle, and `eod` lags the fill level by one cycle.

The bench holds each bit-clock phase for four system cycles and waits six cycles after the last bit before it reads. It samples a popped entry one full cycle after raising `rd_en`, and checks `eod` two cycles after the fill level last changed. Every result is therefore settled before it is compared.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  typedef struct packed {
    logic       chan;
    logic [7:0] data;
  } ssrx_entry_t;
endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta     <= '0;
      sync_out <= '0;
    end else begin
      meta     <= async_in;
      sync_out <= meta;
    end
  end
endmodule

// File: rtl/ssrx_assembler.sv
module ssrx_assembler
  import ssrx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_pcm,
  input  logic        bit_rise,
  input  logic        ws_bit,
  input  logic        sd_bit,
  output logic        push,
  output ssrx_entry_t push_entry
);
  localparam int BYTES = SAMPLE_W / 8;
  localparam int CW    = $clog2(SAMPLE_W + 1);
  localparam int BW    = $clog2(BYTES + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(SAMPLE_W - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(SAMPLE_W);

  logic                mode_q;
  logic [7:0]          bs_sr;
  logic [2:0]          bs_cnt;
  logic                ws_prev, armed, phase_ws;
  logic [CW-1:0]       pc_cnt;
  logic [SAMPLE_W-1:0] pc_sr;
  logic [SAMPLE_W-1:0] out_sr;
  logic [BW-1:0]       bytes_left;
  logic                out_chan;

  always_ff @(posedge clk) begin
    push <= 1'b0;
    if (rst) begin
      mode_q     <= 1'b0;
      bs_sr      <= '0;
      bs_cnt     <= '0;
      ws_prev    <= 1'b0;
      armed      <= 1'b0;
      phase_ws   <= 1'b0;
      pc_cnt     <= '0;
      pc_sr      <= '0;
      out_sr     <= '0;
      bytes_left <= '0;
      out_chan   <= 1'b0;
      push_entry <= '0;
    end else begin
      mode_q <= mode_pcm;
      if (mode_pcm != mode_q) begin
        bs_cnt     <= '0;
        pc_cnt     <= '0;
        armed      <= 1'b0;
        ws_prev    <= 1'b0;
        bytes_left <= '0;
      end else if (bytes_left != '0) begin
        push            <= 1'b1;
        push_entry.data <= out_sr[SAMPLE_W-1 -: 8];
        push_entry.chan <= out_chan;
        out_sr          <= out_sr << 8;
        bytes_left      <= bytes_left - 1'b1;
      end else if (bit_rise) begin
        if (!mode_pcm) begin
          bs_sr  <= {bs_sr[6:0], sd_bit};
          bs_cnt <= bs_cnt + 1'b1;
          if (bs_cnt == 3'd7) begin
            push            <= 1'b1;
            push_entry.data <= {bs_sr[6:0], sd_bit};
            push_entry.chan <= 1'b0;
          end
        end else begin
          ws_prev <= ws_bit;
          if (ws_bit != ws_prev) begin
            armed    <= 1'b1;
            phase_ws <= ws_bit;
            pc_cnt   <= '0;
          end else if (armed && pc_cnt != FULL_CNT) begin
            pc_sr  <= {pc_sr[SAMPLE_W-2:0], sd_bit};
            pc_cnt <= pc_cnt + 1'b1;
            if (pc_cnt == LAST_BIT) begin
              out_sr     <= {pc_sr[SAMPLE_W-2:0], sd_bit};
              out_chan   <= phase_ws;
              bytes_left <= BW'(BYTES);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/ssrx_fifo.sv
module ssrx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic                       rvalid,
  output logic [$clog2(DEPTH):0]     fill
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr && (fill != FULL);
  assign rd_ok = rd && (fill != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
    if (rd_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      fill   <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_ok;
      if (wr_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      fill <= fill + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
    end
  end
endmodule

// File: rtl/serial_stream_rx.sv
module serial_stream_rx
  import ssrx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SAMPLE_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_pcm,
  input  logic       sck,
  input  logic       sws,
  input  logic       sdat,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_chan,
  output logic       rd_valid,
  output logic       data_avail,
  output logic       eod
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] HI_MARK  = (AW+1)'(DEPTH - 4);
  localparam logic [AW:0] LO_MARK  = (AW+1)'(DEPTH / 2);

  logic [2:0]  sync_v;
  logic        sck_d, bit_rise;
  logic        asm_push;
  ssrx_entry_t asm_entry, rd_entry;
  logic [AW:0] fill;

  ssrx_sync #(.W(3)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({sck, sws, sdat}),
    .sync_out(sync_v)
  );

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sync_v[2];
  end
  assign bit_rise = sync_v[2] & ~sck_d;

  ssrx_assembler #(.SAMPLE_W(SAMPLE_W)) u_asm (
    .clk(clk), .rst(rst), .mode_pcm(mode_pcm),
    .bit_rise(bit_rise), .ws_bit(sync_v[1]), .sd_bit(sync_v[0]),
    .push(asm_push), .push_entry(asm_entry)
  );

  ssrx_fifo #(.DEPTH(DEPTH), .W($bits(ssrx_entry_t))) u_fifo (
    .clk(clk), .rst(rst),
    .wr(asm_push), .wdata(asm_entry),
    .rd(rd_en), .rdata(rd_entry), .rvalid(rd_valid),
    .fill(fill)
  );

  assign rd_data    = rd_entry.data;
  assign rd_chan    = rd_entry.chan;
  assign data_avail = (fill != '0);

  always_ff @(posedge clk) begin
    if (rst)                  eod <= 1'b0;
    else if (fill >= HI_MARK) eod <= 1'b1;
    else if (fill <= LO_MARK) eod <= 1'b0;
  end
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   mode_pcm,
  input logic                   rd_en,
  input logic                   data_avail,
  input logic                   rd_valid,
  input logic                   eod,
  input logic                   push,
  input logic [$clog2(DEPTH):0] fill
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] HI_MARK = (AW+1)'(DEPTH - 4);
  localparam logic [AW:0] LO_MARK = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] FULL    = (AW+1)'(DEPTH);

  AST_EOD_SET: assert property (@(posedge clk) disable iff (rst)
    (fill >= HI_MARK) |=> eod);                                  // R7
  AST_EOD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (fill <= LO_MARK) |=> !eod);                                 // R8
  AST_EOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fill > LO_MARK && fill < HI_MARK) |=> $stable(eod));        // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL);                                               // R9
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (fill == $past(fill)) || (fill == $past(fill) + 1'b1) ||
    (fill == $past(fill) - 1'b1));                               // R9
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && data_avail) |=> rd_valid);                         // R10
  AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (push && !mode_pcm && !$changed(mode_pcm)) |=> !push);       // R2
endmodule

bind serial_stream_rx ssrx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .mode_pcm(mode_pcm), .rd_en(rd_en),
  .data_avail(data_avail), .rd_valid(rd_valid), .eod(eod),
  .push(asm_push), .fill(fill)
);

// File: tb/sim_serial_stream_rx.sv
`timescale 1ns/1ps
module sim_serial_stream_rx;
  logic clk = 1'b0, rst = 1'b1, mode_pcm = 1'b0;
  logic sck = 1'b0, sws = 1'b0, sdat = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_chan, rd_valid, data_avail, eod;
  int n_chk = 0, n_fail = 0;
  logic [7:0] got_d;
  logic       got_c;

  always #2 clk = ~clk;

  serial_stream_rx u0 (
    .clk(clk), .rst(rst), .mode_pcm(mode_pcm), .sck(sck), .sws(sws),
    .sdat(sdat), .rd_en(rd_en), .rd_data(rd_data), .rd_chan(rd_chan),
    .rd_valid(rd_valid), .data_avail(data_avail), .eod(eod)
  );

  // {strobe pattern, byte}
  localparam logic [15:0] BS_VEC [5] = '{16'h00A5, 16'hFF3C, 16'h5501,
                                         16'hA3F0, 16'h0F7E};

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic ws, input logic d);
    @(negedge clk); sck = 1'b0; sws = ws; sdat = d;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic [7:0] wsp);
    for (int i = 7; i >= 0; i--) send_bit(wsp[i], b[i]);
  endtask

  task automatic send_word(input logic ws, input logic [15:0] w, input int extra);
    send_bit(ws, 1'b0);
    for (int i = 15; i >= 0; i--) send_bit(ws, w[i]);
    for (int i = 0; i < extra; i++) send_bit(ws, 1'b1);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pop(output logic [7:0] d, output logic c, input string req);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check({8'h00, rd_valid}, 9'h001, req);
    d = rd_data; c = rd_chan;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R10 reset state
    check({8'h00, data_avail}, 9'h000, "R10 data_avail");
    check({8'h00, eod},        9'h000, "R10 eod");
    check({8'h00, rd_valid},   9'h000, "R10 rd_valid");

    // R1 R2 R3: table of bytes with strobe noise
    foreach (BS_VEC[i]) send_byte(BS_VEC[i][7:0], BS_VEC[i][15:8]);
    settle();
    foreach (BS_VEC[i]) begin
      pop(got_d, got_c, "R10 rd_valid");
      check({got_c, got_d}, {1'b0, BS_VEC[i][7:0]}, "R2 R3 byte");
    end
    check({8'h00, data_avail}, 9'h000, "R1 count");

    // PCM mode
    mode_pcm = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) send_bit(1'b0, 1'b1);
    settle();
    check({8'h00, data_avail}, 9'h000, "R6 before strobe change");
    send_word(1'b1, 16'hBEEF, 0);
    send_word(1'b0, 16'h1234, 4);
    settle();
    pop(got_d, got_c, "R10"); check({got_c, got_d}, 9'h1BE, "R4 R5 right hi");
    pop(got_d, got_c, "R10"); check({got_c, got_d}, 9'h1EF, "R5 right lo");
    pop(got_d, got_c, "R10"); check({got_c, got_d}, 9'h012, "R5 left hi");
    pop(got_d, got_c, "R10"); check({got_c, got_d}, 9'h034, "R5 left lo");
    repeat (2) @(negedge clk);
    check({8'h00, data_avail}, 9'h000, "R6 extra bits");

    // R11 partial byte discarded on mode change
    mode_pcm = 1'b0;
    repeat (4) @(negedge clk);
    send_bit(1'b0, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b0, 1'b1);
    mode_pcm = 1'b1; repeat (4) @(negedge clk);
    mode_pcm = 1'b0; repeat (4) @(negedge clk);
    send_byte(8'h5A, 8'h00);
    settle();
    pop(got_d, got_c, "R10"); check({got_c, got_d}, 9'h05A, "R11 realign");

    // R7 R8 hysteresis
    for (int i = 0; i < 11; i++) send_byte(8'(8'h10 + i), 8'h00);
    settle();
    check({8'h00, eod}, 9'h000, "R7 below mark");
    send_byte(8'h1B, 8'h00);
    settle();
    check({8'h00, eod}, 9'h001, "R7 at mark");
    for (int i = 0; i < 3; i++) pop(got_d, got_c, "R10");
    repeat (2) @(negedge clk);
    check({8'h00, eod}, 9'h001, "R8 hold");
    pop(got_d, got_c, "R10");
    repeat (2) @(negedge clk);
    check({8'h00, eod}, 9'h000, "R8 release");
    for (int i = 4; i < 12; i++) begin
      pop(got_d, got_c, "R10");
      check({got_c, got_d}, {1'b0, 8'(8'h10 + i)}, "R8 order");
    end

    // R9 overflow
    for (int i = 0; i < 18; i++) send_byte(8'(8'h80 + i), 8'h00);
    settle();
    for (int i = 0; i < 16; i++) begin
      pop(got_d, got_c, "R10");
      check({got_c, got_d}, {1'b0, 8'(8'h80 + i)}, "R9 kept");
    end
    repeat (2) @(negedge clk);
    check({8'h00, data_avail}, 9'h000, "R9 dropped");

    summary();
  end
endmodule